// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits beside one processor core and keeps track of a single exclusive reservation. That reservation is what lets load-exclusive / store-exclusive sequences work. On each clock the core may present one memory event:

- an ordinary load
- an ordinary store
- a load-exclusive
- a store-exclusive

Every event carries its full address and an access-size code. The monitor does not touch memory and does not decode instructions. It only keeps the reservation state up to date, and for each store-exclusive it gives back a registered verdict one cycle later.

The verdict follows the software convention: status 0 means the store may go ahead, and 1 means it failed. A passing verdict from this block is only the local half of the decision. A separate system-wide monitor must also agree before memory is written.

The state machine has two states, named by the enum `mon_state_e`:

- `MON_OPEN`: no reservation is held.
- `MON_EXCL`: a reservation is held. It is tagged with an address and a size.

The transitions are:

- **TAKE**: a load-exclusive moves Open or Exclusive to Exclusive and records a new tag.
- **DROP_PLAIN**: an ordinary load or store moves Exclusive to Open.
- **DROP_STEX**: a store-exclusive moves Exclusive to Open, whether it passes or fails.
- **STAY**: an idle cycle, an ordinary access in Open, or a store-exclusive in Open leaves the state unchanged.

Events arrive as a four-bit request vector, one bit per kind. If more than one bit is set in a cycle, the lowest-numbered bit is served and a sticky error flag is raised.

Top module: `lxm_monitor`

## Requirements
- R1: After reset the monitor is Open (`mon_excl`=0), with a zero tag address and tag size 0 (none). `stx_done`, `stx_fail` and `multi_err` are all 0.
- R2: A load-exclusive (request bit 2) moves the monitor to Exclusive from either state and records its full address and its size code. The size codes are none=0, byte=1, halfword=2, word=4. A second load-exclusive replaces the first tag.
- R3: An ordinary load (bit 0) or store (bit 1) seen in Exclusive returns the monitor to Open, whatever its address.
- R4: A store-exclusive (bit 3) in Exclusive passes only if its address equals the tag address bit for bit and its size code equals the tagged size. The verdict is reported on `stx_fail` as 0 for pass and 1 for fail.
- R5: After any store-exclusive the monitor is Open and the tag is cleared, so an immediate second store-exclusive to the same address fails.
- R6: A store-exclusive that arrives while the monitor is Open fails.
- R7: `stx_done` is 1 in exactly the cycle after a store-exclusive is served, and 0 at every other time.
- R8: When several request bits are set in one cycle, only the lowest-numbered one takes effect. `multi_err` then becomes 1 and stays 1 until reset.
- R9: A cycle with no request leaves the state and the tag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_req | input | 4 | One bit per event kind: 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| ev_addr | input | ADDR_W | Full byte address of the access |
| ev_size | input | SIZE_W | Access size code (0 none, 1 byte, 2 half, 4 word) |
| stx_done | output | 1 | Store-exclusive verdict valid |
| stx_fail | output | 1 | Verdict: 0 pass, 1 fail (held between verdicts) |
| mon_excl | output | 1 | 1 while a reservation is held |
| multi_err | output | 1 | Sticky: more than one request bit was seen in a cycle |

## Verification
Every result of this block is due on the first rising edge after the event is presented:

- the new `mon_excl` state
- the `stx_done`/`stx_fail` verdict for a store-exclusive
- the `multi_err` flag

Stimulus is driven on the falling edge. Each result is sampled a short delay after the following rising edge and compared with a bench reference model that has already been updated for that event. Any tag effect that cannot be seen directly (R2, R9) is exposed by a store-exclusive issued afterwards, whose verdict is again checked one edge later.

// File: rtl/lxm_pkg.sv
`timescale 1ns/1ps
package lxm_pkg;
    typedef enum logic {
        MON_OPEN = 1'b0,
        MON_EXCL = 1'b1
    } mon_state_e;

    typedef enum logic [1:0] {
        EV_LOAD  = 2'd0,
        EV_STORE = 2'd1,
        EV_LDEX  = 2'd2,
        EV_STEX  = 2'd3
    } ev_kind_e;

    localparam int N_KIND = 4;
endpackage

// File: rtl/lxm_arbiter.sv
`timescale 1ns/1ps
module lxm_arbiter
    import lxm_pkg::*;
(
    input  logic [N_KIND-1:0] req,
    output logic              pick_any,
    output ev_kind_e          pick_kind,
    output logic              pick_multi
);
    logic [1:0] idx;

    // lowest set bit wins
    always_comb begin
        idx = 2'd0;
        for (int k = N_KIND - 1; k >= 0; k--) begin
            if (req[k]) idx = 2'(k);
        end
    end

    assign pick_any   = |req;
    assign pick_kind  = ev_kind_e'(idx);
    assign pick_multi = (req & (req - 1'b1)) != '0;
endmodule

// File: rtl/lxm_reservation.sv
`timescale 1ns/1ps
module lxm_reservation
    import lxm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_any,
    input  ev_kind_e          ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [SIZE_W-1:0] ev_size,
    output mon_state_e        state,
    output logic [ADDR_W-1:0] tag_addr,
    output logic [SIZE_W-1:0] tag_size
);
    mon_state_e        nxt_state;
    logic [ADDR_W-1:0] nxt_addr;
    logic [SIZE_W-1:0] nxt_size;

    always_comb begin
        nxt_state = state;
        nxt_addr  = tag_addr;
        nxt_size  = tag_size;
        if (ev_any) begin
            unique case (ev_kind)
                EV_LDEX: begin             // TAKE
                    nxt_state = MON_EXCL;
                    nxt_addr  = ev_addr;
                    nxt_size  = ev_size;
                end
                EV_LOAD, EV_STORE: begin   // DROP_PLAIN or STAY
                    if (state == MON_EXCL) begin
                        nxt_state = MON_OPEN;
                        nxt_addr  = '0;
                        nxt_size  = '0;
                    end
                end
                EV_STEX: begin             // DROP_STEX or STAY
                    nxt_state = MON_OPEN;
                    nxt_addr  = '0;
                    nxt_size  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MON_OPEN;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_addr <= '0;
            tag_size <= '0;
        end else begin
            tag_addr <= nxt_addr;
            tag_size <= nxt_size;
        end
    end
endmodule

// File: rtl/lxm_verdict.sv
`timescale 1ns/1ps
module lxm_verdict
    import lxm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_any,
    input  ev_kind_e          ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [SIZE_W-1:0] ev_size,
    input  mon_state_e        state,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [SIZE_W-1:0] tag_size,
    output logic              done,
    output logic              fail
);
    logic is_stex;
    logic hit;

    assign is_stex = ev_any && (ev_kind == EV_STEX);
    assign hit     = (state == MON_EXCL) && (ev_addr == tag_addr) && (ev_size == tag_size);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else begin
            done <= is_stex;
            if (is_stex) fail <= !hit;
        end
    end
endmodule

// File: rtl/lxm_monitor.sv
`timescale 1ns/1ps
module lxm_monitor
    import lxm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ev_req,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [SIZE_W-1:0] ev_size,
    output logic              stx_done,
    output logic              stx_fail,
    output logic              mon_excl,
    output logic              multi_err
);
    logic              pick_any;
    ev_kind_e          pick_kind;
    logic              pick_multi;
    mon_state_e        state;
    logic [ADDR_W-1:0] tag_addr;
    logic [SIZE_W-1:0] tag_size;

    lxm_arbiter u_arb (
        .req        (ev_req),
        .pick_any   (pick_any),
        .pick_kind  (pick_kind),
        .pick_multi (pick_multi)
    );

    lxm_reservation #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_any   (pick_any),
        .ev_kind  (pick_kind),
        .ev_addr  (ev_addr),
        .ev_size  (ev_size),
        .state    (state),
        .tag_addr (tag_addr),
        .tag_size (tag_size)
    );

    lxm_verdict #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_verd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_any   (pick_any),
        .ev_kind  (pick_kind),
        .ev_addr  (ev_addr),
        .ev_size  (ev_size),
        .state    (state),
        .tag_addr (tag_addr),
        .tag_size (tag_size),
        .done     (stx_done),
        .fail     (stx_fail)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          multi_err <= 1'b0;
        else if (pick_multi) multi_err <= 1'b1;
    end

    assign mon_excl = (state == MON_EXCL);
endmodule

// File: rtl/lxm_monitor_sva.sv
`timescale 1ns/1ps
module lxm_monitor_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       pick_any,
    input logic [1:0] pick_kind,
    input logic       stx_done,
    input logic       stx_fail,
    input logic       mon_excl,
    input logic       multi_err
);
    logic stex_c, ldex_c, plain_c;
    assign stex_c  = pick_any && (pick_kind == 2'd3);
    assign ldex_c  = pick_any && (pick_kind == 2'd2);
    assign plain_c = pick_any && (pick_kind <= 2'd1);

    assert_ldex_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ldex_c |=> mon_excl);
    assert_plain_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        plain_c |=> !mon_excl);
    assert_stex_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stex_c |=> !mon_excl);
    assert_open_stex_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stex_c && !mon_excl) |=> (stx_done && stx_fail));
    assert_done_after_stex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stex_c |=> stx_done);
    assert_done_only_after_stex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stex_c |=> !stx_done);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        multi_err |=> multi_err);
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_any |=> $stable(mon_excl));
endmodule

bind lxm_monitor lxm_monitor_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_any  (pick_any),
    .pick_kind (pick_kind),
    .stx_done  (stx_done),
    .stx_fail  (stx_fail),
    .mon_excl  (mon_excl),
    .multi_err (multi_err)
);

// File: tb/lxm_monitor_test.sv
`timescale 1ns/1ps
module lxm_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ev_req = 4'd0;
    logic [31:0] ev_addr = 32'd0;
    logic [2:0]  ev_size = 3'd0;
    logic        stx_done, stx_fail, mon_excl, multi_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model
    bit          m_excl = 0;
    logic [31:0] m_addr = 0;
    logic [2:0]  m_size = 0;
    bit          m_fail = 0;
    bit          m_err = 0;

    lxm_monitor uut (
        .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_addr(ev_addr), .ev_size(ev_size),
        .stx_done(stx_done), .stx_fail(stx_fail), .mon_excl(mon_excl), .multi_err(multi_err)
    );

    always #10 clk = ~clk;

    function automatic int pick(input logic [3:0] r);
        for (int k = 0; k < 4; k++) if (r[k]) return k;
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Drive one event, advance one edge, check all outputs against the model.
    task automatic ev(input logic [3:0] r, input logic [31:0] a, input logic [2:0] s, input string tag);
        int  k;
        bit  exp_done;
        @(negedge clk);
        ev_req = r; ev_addr = a; ev_size = s;
        k = pick(r);
        exp_done = (k == 3);
        if (r != 4'd0 && (r & (r - 4'd1)) != 4'd0) m_err = 1;
        case (k)
            0, 1: if (m_excl) begin m_excl = 0; m_addr = 0; m_size = 0; end
            2: begin m_excl = 1; m_addr = a; m_size = s; end
            3: begin
                m_fail = !(m_excl && a == m_addr && s == m_size);
                m_excl = 0; m_addr = 0; m_size = 0;
            end
            default: ;
        endcase
        @(posedge clk); #2;
        chk(tag, "stx_done", stx_done, exp_done);
        if (exp_done) chk(tag, "stx_fail", stx_fail, m_fail);
        chk(tag, "mon_excl", mon_excl, m_excl);
        chk(tag, "multi_err", multi_err, m_err);
        ev_req = 4'd0;
    endtask

    localparam logic [3:0] LD = 4'b0001, ST = 4'b0010, LX = 4'b0100, SX = 4'b1000;

    initial begin
        logic [31:0] pool [4];
        logic [2:0]  szs [5];
        void'($urandom(32'd4242));
        pool[0] = 32'h1000; pool[1] = 32'h1004; pool[2] = 32'h1800; pool[3] = 32'h1001;
        szs[0] = 3'd0; szs[1] = 3'd1; szs[2] = 3'd2; szs[3] = 3'd4; szs[4] = 3'd3;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1", "mon_excl", mon_excl, 1'b0);
        chk("R1", "stx_done", stx_done, 1'b0);
        chk("R1", "stx_fail", stx_fail, 1'b0);
        chk("R1", "multi_err", multi_err, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R6: stex in Open fails, even with zero addr and none size matching the reset tag
        ev(SX, 32'h0, 3'd0, "R6");
        // R4 exact match passes
        ev(LX, 32'h1000, 3'd4, "R2"); ev(SX, 32'h1000, 3'd4, "R4");
        // R5: repeat stex fails
        ev(SX, 32'h1000, 3'd4, "R5");
        // R4 address mismatch (low bit only)
        ev(LX, 32'h1000, 3'd4, "R2"); ev(SX, 32'h1001, 3'd4, "R4");
        // R4 size mismatch
        ev(LX, 32'h1000, 3'd4, "R2"); ev(SX, 32'h1000, 3'd2, "R4");
        // R3 ordinary load / store elsewhere clears
        ev(LX, 32'h1000, 3'd4, "R2"); ev(LD, 32'h9999, 3'd1, "R3"); ev(SX, 32'h1000, 3'd4, "R3");
        ev(LX, 32'h1000, 3'd4, "R2"); ev(ST, 32'h2000, 3'd4, "R3"); ev(SX, 32'h1000, 3'd4, "R3");
        // R2 retag by second ldex
        ev(LX, 32'h1000, 3'd4, "R2"); ev(LX, 32'h1800, 3'd1, "R2"); ev(SX, 32'h1000, 3'd4, "R2");
        ev(LX, 32'h1000, 3'd4, "R2"); ev(LX, 32'h1800, 3'd1, "R2"); ev(SX, 32'h1800, 3'd1, "R2");
        // R9 idle cycles keep the tag
        ev(LX, 32'h1004, 3'd2, "R2"); ev(4'd0, 32'h0, 3'd0, "R9"); ev(4'd0, 32'h5, 3'd1, "R9");
        ev(SX, 32'h1004, 3'd2, "R9");
        // R8 multi request: ldex+stex -> ldex wins, error set
        ev(LX | SX, 32'h1000, 3'd4, "R8");
        chk("R8", "mon_excl after ldex+stex", mon_excl, 1'b1);
        ev(SX, 32'h1000, 3'd4, "R8");
        ev(LX, 32'h1000, 3'd4, "R2"); ev(ST | SX, 32'h1000, 3'd4, "R8");
        chk("R8", "multi_err sticky", multi_err, 1'b1);
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            int u;
            u = $urandom_range(0, 15);
            if (u == 0) r = 4'($urandom_range(0, 15));
            else if (u < 3) r = 4'd0;
            else if (u < 8) r = LX;
            else if (u < 12) r = SX;
            else r = (u < 14) ? LD : ST;
            ev(r, pool[$urandom_range(0, 3)], szs[$urandom_range(0, 4)], "R4");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule